// File: doc/BRIEF.md
# Display Controller Command Decoder and Address Counter

This block sits behind the host port of a character display controller. The host writes bytes with a register-select bit. Select 0 carries an instruction and select 1 carries data for a display memory. The block decodes each instruction. It keeps one address counter that is shared by three display memories and a small annunciator area: the character-code memory, the user-glyph memory and the segment memory. It then issues one registered write strobe, together with target, address and data, for each data byte. The most recent address-set instruction decides which memory the counter points into. That choice sets the counter's wrap range and sets whether data bytes are written at full width or cut to five bits.

A clear-screen instruction starts a sequencer. The sequencer writes the space code into every character-code location, one location per clock. While it runs, the busy bit in the status byte is high and host writes are dropped. Three small control fields (contrast, scroll and power) are latched from their instructions and driven out unchanged. The memories themselves and the display scan are outside this block.

Top module: `lcdc_cmd_ctrl`

## Requirements
- R1: `status_o` bit 7 is the busy flag and bits 6:0 are the address counter. While `rst_n` is low, the status reads 80H. After reset it reads 00H, the target is the character-code memory and all latched fields are 0.
- R2: An instruction byte with bit 7 = 1 loads its bits 6:0 into the address counter and selects the character-code memory (target code 0).
- R3: Instruction `011aaaaa` loads a 5-bit address and selects the glyph memory (code 1). Instruction `010aaaaa` loads a 5-bit address and selects the segment memory (code 2). Instruction `0011aaaa` loads a 4-bit address and selects the annunciator area (code 3). The address is visible in the status byte on the next cycle.
- R4: A data byte (select = 1) produces, one cycle later, a single-cycle `mem_we_o` at the current counter value with the current target. Character-code and annunciator writes carry all 8 bits. Glyph and segment writes carry bits 4:0 with bits 7:5 forced to 0.
- R5: After each data write the counter advances by one. In the character-code memory it goes from 4BH to 00H and counts modulo 128 elsewhere. In the glyph and segment memories it counts modulo 32, and in the annunciator area modulo 16.
- R6: Instruction `0000001x` sets the counter to 0 and selects the character-code memory without any memory write.
- R7: Instruction `00000001` writes 20H to character-code addresses 00H..4BH in ascending order, one per clock. Busy is high for exactly 76 cycles after acceptance and the counter reads 0 throughout and afterwards.
- R8: Host writes presented while busy is high, or while reset is asserted, are dropped. They change no counter, target, latch or memory.
- R9: Instruction `0001cccc` latches `contrast_o`, `0010ssss` latches `scroll_o` and `00001ppp` latches `power_o`. Each field holds until it is written again, and none of them moves the counter.
- R10: Instructions `00000000` and `000001xx` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host write strobe, one byte per cycle |
| host_rs_i | input | 1 | Register select: 0 instruction, 1 data |
| host_wdata_i | input | 8 | Host byte |
| status_o | output | 8 | Busy flag and address counter |
| mem_we_o | output | 1 | Memory write strobe |
| mem_tgt_o | output | 2 | Memory target: 0 char, 1 glyph, 2 segment, 3 annunciator |
| mem_addr_o | output | 7 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| contrast_o | output | 4 | Latched contrast field |
| scroll_o | output | 4 | Latched scroll field |
| power_o | output | 3 | Latched power field |

## Verification
The bench sweeps every address-set value for all four targets. It runs data bursts across each wrap point: 4BH to 00H, 7FH to 00H, 1FH to 00H and 0FH to 00H. A counter that wrapped by bit width alone would place the 77th character byte at 4CH instead of 00H. A missing five-bit cut would leave high bits in glyph data. The clear sequence is checked for its exact 76-cycle busy window, its ascending address order and its final counter of 0; an off-by-one end test shows up as 75 or 77 busy cycles. Writes injected during the fill and during reset must leave the counter, the latches and the memory image untouched; a design that accepted them would move the counter or overwrite a cleared location.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int BYTE_W   = 8;
    localparam int AC_W     = 7;
    localparam int NARROW_W = 5;
    localparam int ANN_W    = 4;
    localparam int CTR_W    = 4;
    localparam int SCR_W    = 4;
    localparam int PWR_W    = 3;

    typedef enum logic [1:0] {
        TGT_DD  = 2'd0,
        TGT_CG  = 2'd1,
        TGT_SEG = 2'd2,
        TGT_ANN = 2'd3
    } tgt_e;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_CLEAR,
        OP_HOME,
        OP_PWR,
        OP_CTR,
        OP_SCR,
        OP_SET_ANN,
        OP_SET_SEG,
        OP_SET_CG,
        OP_SET_DD
    } op_e;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_FILL = 1'b1
    } mode_e;

    typedef struct packed {
        op_e             op;
        logic [AC_W-1:0] arg;
    } cmd_t;

endpackage

// File: rtl/lcdc_cmd_decode.sv
module lcdc_cmd_decode
    import lcdc_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output cmd_t              cmd_o
);

    always_comb begin
        cmd_o.op  = OP_NOP;
        cmd_o.arg = '0;
        casez (byte_i)
            8'b1???_????: begin
                cmd_o.op  = OP_SET_DD;
                cmd_o.arg = byte_i[AC_W-1:0];
            end
            8'b011?_????: begin
                cmd_o.op  = OP_SET_CG;
                cmd_o.arg = AC_W'(byte_i[NARROW_W-1:0]);
            end
            8'b010?_????: begin
                cmd_o.op  = OP_SET_SEG;
                cmd_o.arg = AC_W'(byte_i[NARROW_W-1:0]);
            end
            8'b0011_????: begin
                cmd_o.op  = OP_SET_ANN;
                cmd_o.arg = AC_W'(byte_i[ANN_W-1:0]);
            end
            8'b0010_????: begin
                cmd_o.op  = OP_SCR;
                cmd_o.arg = AC_W'(byte_i[SCR_W-1:0]);
            end
            8'b0001_????: begin
                cmd_o.op  = OP_CTR;
                cmd_o.arg = AC_W'(byte_i[CTR_W-1:0]);
            end
            8'b0000_1???: begin
                cmd_o.op  = OP_PWR;
                cmd_o.arg = AC_W'(byte_i[PWR_W-1:0]);
            end
            8'b0000_001?: cmd_o.op = OP_HOME;
            8'b0000_0001: cmd_o.op = OP_CLEAR;
            default:      cmd_o.op = OP_NOP;
        endcase
    end

endmodule

// File: rtl/lcdc_ac_step.sv
module lcdc_ac_step
    import lcdc_pkg::*;
#(
    parameter int DD_LAST = 75
) (
    input  tgt_e            tgt_i,
    input  logic [AC_W-1:0] ac_i,
    output logic [AC_W-1:0] ac_next_o
);

    localparam int AC_MAX = (1 << AC_W) - 1;

    logic [AC_W-1:0] dd_next;

    // Character-memory step: a full-range memory needs no end compare.
    generate
        if (DD_LAST >= AC_MAX) begin : g_dd_full
            assign dd_next = ac_i + AC_W'(1);
        end else begin : g_dd_short
            assign dd_next = (ac_i == AC_W'(DD_LAST)) ? '0 : ac_i + AC_W'(1);
        end
    endgenerate

    logic [NARROW_W-1:0] narrow_next;
    logic [ANN_W-1:0]    ann_next;

    assign narrow_next = ac_i[NARROW_W-1:0] + NARROW_W'(1);
    assign ann_next    = ac_i[ANN_W-1:0] + ANN_W'(1);

    always_comb begin
        unique case (tgt_i)
            TGT_DD:         ac_next_o = dd_next;
            TGT_CG, TGT_SEG: ac_next_o = AC_W'(narrow_next);
            default:        ac_next_o = AC_W'(ann_next);
        endcase
    end

endmodule

// File: rtl/lcdc_cmd_ctrl.sv
module lcdc_cmd_ctrl
    import lcdc_pkg::*;
#(
    parameter int                DD_LAST   = 75,
    parameter logic [BYTE_W-1:0] FILL_CHAR = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we_i,
    input  logic              host_rs_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    output logic [BYTE_W-1:0] status_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_tgt_o,
    output logic [AC_W-1:0]   mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic [CTR_W-1:0]  contrast_o,
    output logic [SCR_W-1:0]  scroll_o,
    output logic [PWR_W-1:0]  power_o
);

    localparam logic [AC_W-1:0] FILL_END = AC_W'(DD_LAST);

    typedef struct packed {
        mode_e             mode;
        tgt_e              tgt;
        logic [AC_W-1:0]   ac;
        logic [AC_W-1:0]   fill;
        logic              mem_we;
        tgt_e              mem_tgt;
        logic [AC_W-1:0]   mem_addr;
        logic [BYTE_W-1:0] mem_wdata;
        logic [CTR_W-1:0]  ctr;
        logic [SCR_W-1:0]  scr;
        logic [PWR_W-1:0]  pwr;
    } state_t;

    state_t q, d;

    cmd_t            cmd;
    logic [AC_W-1:0] ac_next;
    logic            accept;

    lcdc_cmd_decode u_decode (
        .byte_i (host_wdata_i),
        .cmd_o  (cmd)
    );

    lcdc_ac_step #(
        .DD_LAST (DD_LAST)
    ) u_step (
        .tgt_i     (q.tgt),
        .ac_i      (q.ac),
        .ac_next_o (ac_next)
    );

    assign accept = (q.mode == MODE_RUN) && host_we_i;

    always_comb begin
        d        = q;
        d.mem_we = 1'b0;
        if (q.mode == MODE_FILL) begin
            d.mem_we    = 1'b1;
            d.mem_tgt   = TGT_DD;
            d.mem_addr  = q.fill;
            d.mem_wdata = FILL_CHAR;
            if (q.fill == FILL_END) begin
                d.mode = MODE_RUN;
                d.fill = '0;
                d.ac   = '0;
                d.tgt  = TGT_DD;
            end else begin
                d.fill = q.fill + AC_W'(1);
            end
        end else if (accept && host_rs_i) begin
            d.mem_we   = 1'b1;
            d.mem_tgt  = q.tgt;
            d.mem_addr = q.ac;
            if (q.tgt == TGT_CG || q.tgt == TGT_SEG) begin
                d.mem_wdata = BYTE_W'(host_wdata_i[NARROW_W-1:0]);
            end else begin
                d.mem_wdata = host_wdata_i;
            end
            d.ac = ac_next;
        end else if (accept) begin
            case (cmd.op)
                OP_SET_DD:  begin d.ac = cmd.arg; d.tgt = TGT_DD;  end
                OP_SET_CG:  begin d.ac = cmd.arg; d.tgt = TGT_CG;  end
                OP_SET_SEG: begin d.ac = cmd.arg; d.tgt = TGT_SEG; end
                OP_SET_ANN: begin d.ac = cmd.arg; d.tgt = TGT_ANN; end
                OP_HOME:    begin d.ac = '0;      d.tgt = TGT_DD;  end
                OP_CLEAR: begin
                    d.mode = MODE_FILL;
                    d.fill = '0;
                    d.ac   = '0;
                    d.tgt  = TGT_DD;
                end
                OP_CTR:  d.ctr = cmd.arg[CTR_W-1:0];
                OP_SCR:  d.scr = cmd.arg[SCR_W-1:0];
                OP_PWR:  d.pwr = cmd.arg[PWR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: MODE_RUN, tgt: TGT_DD, mem_tgt: TGT_DD, default: '0};
        end else begin
            q <= d;
        end
    end

    assign status_o    = {(q.mode == MODE_FILL) || !rst_n, q.ac};
    assign mem_we_o    = q.mem_we;
    assign mem_tgt_o   = q.mem_tgt;
    assign mem_addr_o  = q.mem_addr;
    assign mem_wdata_o = q.mem_wdata;
    assign contrast_o  = q.ctr;
    assign scroll_o    = q.scr;
    assign power_o     = q.pwr;

    // R2: a character-address instruction shows up in the status byte
    p_dd_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_RUN && host_we_i && !host_rs_i && host_wdata_i[7])
        |=> (status_o[AC_W-1:0] == $past(host_wdata_i[AC_W-1:0]) && q.tgt == TGT_DD));

    // R4: an accepted data byte strobes memory at the old counter and target
    p_wr_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_RUN && host_we_i && host_rs_i)
        |=> (mem_we_o && mem_addr_o == $past(q.ac) && mem_tgt_o == $past(q.tgt)));

    // R4: narrow memories never receive upper bits
    p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && (mem_tgt_o == TGT_CG || mem_tgt_o == TGT_SEG))
        |-> (mem_wdata_o[BYTE_W-1:NARROW_W] == '0));

    // R7: every fill cycle writes the space code into the character memory
    p_fill_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_FILL)
        |=> (mem_we_o && mem_tgt_o == TGT_DD && mem_wdata_o == FILL_CHAR));

    // R7: the counter is at 0 on character memory when the fill ends
    p_fill_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.mode == MODE_FILL) |-> (status_o[AC_W-1:0] == '0 && q.tgt == TGT_DD));

    // R8: host writes during the fill leave the latched fields alone
    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_FILL && host_we_i)
        |=> ($stable(contrast_o) && $stable(scroll_o) && $stable(power_o)));

endmodule

// File: tb/lcdc_cmd_ctrl_tb.sv
module lcdc_cmd_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic       host_rs = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] status_o;
    logic       mem_we;
    logic [1:0] mem_tgt;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [3:0] contrast;
    logic [3:0] scroll;
    logic [2:0] power;

    always #2.5 clk = ~clk;

    lcdc_cmd_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we_i    (host_we),
        .host_rs_i    (host_rs),
        .host_wdata_i (host_wdata),
        .status_o     (status_o),
        .mem_we_o     (mem_we),
        .mem_tgt_o    (mem_tgt),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .contrast_o   (contrast),
        .scroll_o     (scroll),
        .power_o      (power)
    );

    int checks = 0;
    int fails  = 0;

    // shadow memories filled from the memory port
    int sh_dd  [128];
    int sh_cg  [32];
    int sh_seg [32];
    int sh_ann [16];
    int n_wr   [4];
    int dlog   [512];
    int dlog_n = 0;
    int exp_dd [128];

    initial begin
        for (int i = 0; i < 128; i++) begin sh_dd[i] = -1; exp_dd[i] = -1; end
        for (int i = 0; i < 32; i++) begin sh_cg[i] = -1; sh_seg[i] = -1; end
        for (int i = 0; i < 16; i++) sh_ann[i] = -1;
        for (int i = 0; i < 4; i++) n_wr[i] = 0;
    end

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            n_wr[mem_tgt]++;
            case (mem_tgt)
                2'd0: begin
                    sh_dd[mem_addr] = mem_wdata;
                    if (dlog_n < 512) dlog[dlog_n] = mem_addr;
                    dlog_n++;
                end
                2'd1: sh_cg[mem_addr[4:0]] = mem_wdata;
                2'd2: sh_seg[mem_addr[4:0]] = mem_wdata;
                default: sh_ann[mem_addr[3:0]] = mem_wdata;
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic rs, input logic [7:0] b);
        host_rs    = rs;
        host_wdata = b;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int total_wr();
        return n_wr[0] + n_wr[1] + n_wr[2] + n_wr[3];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int snap;
        int base;
        int busy_cnt;
        int v;

        // R1 / R8: reset state, host activity during reset is ignored
        host_we = 1'b1; host_rs = 1'b1; host_wdata = 8'h85;
        idle(3);
        chk("R1 status in reset", status_o, 8'h80);
        host_rs = 1'b0;
        idle(1);
        host_we = 1'b0;
        rst_n   = 1'b1;
        idle(1);
        chk("R1 status after reset", status_o, 8'h00);
        chk("R1 contrast after reset", contrast, 0);
        chk("R1 scroll after reset", scroll, 0);
        chk("R1 power after reset", power, 0);
        chk("R8 no write from reset activity", total_wr(), 0);

        // R2: full sweep of character-address set
        for (int a = 0; a < 128; a++) begin
            host_write(1'b0, 8'h80 | 8'(a));
            chk("R2 char address set", status_o, a);
        end

        // R3: glyph, segment, annunciator address sweeps
        for (int a = 0; a < 32; a++) begin
            host_write(1'b0, 8'h60 | 8'(a));
            chk("R3 glyph address set", status_o, a);
            host_write(1'b0, 8'h40 | 8'(a));
            chk("R3 segment address set", status_o, a);
        end
        for (int a = 0; a < 16; a++) begin
            host_write(1'b0, 8'h30 | 8'(a));
            chk("R3 annunciator address set", status_o, a);
        end
        chk("R3 address sets write nothing", total_wr(), 0);

        // R4 / R5: character-memory burst across the 4BH wrap
        host_write(1'b0, 8'h80);
        for (int i = 0; i < 80; i++) begin
            v = (i * 37 + 11) & 8'hFF;
            exp_dd[i % 76] = v;
            host_write(1'b1, 8'(v));
            chk("R5 char counter step", status_o, (i + 1) % 76);
        end
        idle(1);
        for (int a = 0; a < 76; a++) chk("R4 char memory image", sh_dd[a], exp_dd[a]);
        chk("R4 char write count", n_wr[0], 80);

        // R5: above-range char address counts modulo 128
        host_write(1'b0, 8'hFE);
        host_write(1'b1, 8'h5A);
        host_write(1'b1, 8'hA5);
        chk("R5 char wrap from 7FH", status_o, 0);
        idle(1);
        chk("R4 char write at 7FH", sh_dd[127], 8'hA5);

        // R4 / R5: glyph burst across 1FH with 5-bit cut
        host_write(1'b0, 8'h60 | 8'd30);
        host_write(1'b1, 8'hFF);
        host_write(1'b1, 8'hE5);
        host_write(1'b1, 8'h3A);
        chk("R5 glyph wrap", status_o, 1);
        idle(1);
        chk("R4 glyph cut at 30", sh_cg[30], 8'h1F);
        chk("R4 glyph cut at 31", sh_cg[31], 8'h05);
        chk("R4 glyph cut at 0", sh_cg[0], 8'h1A);
        chk("R4 glyph count", n_wr[1], 3);

        // R4 / R5: segment burst
        host_write(1'b0, 8'h40 | 8'd31);
        host_write(1'b1, 8'hC7);
        host_write(1'b1, 8'h2B);
        chk("R5 segment wrap", status_o, 1);
        idle(1);
        chk("R4 segment cut at 31", sh_seg[31], 8'h07);
        chk("R4 segment cut at 0", sh_seg[0], 8'h0B);
        chk("R4 segment count", n_wr[2], 2);

        // R4 / R5: annunciator keeps 8 bits, wraps at 16
        host_write(1'b0, 8'h3F);
        host_write(1'b1, 8'hE9);
        host_write(1'b1, 8'hB6);
        chk("R5 annunciator wrap", status_o, 1);
        idle(1);
        chk("R4 annunciator full byte 15", sh_ann[15], 8'hE9);
        chk("R4 annunciator full byte 0", sh_ann[0], 8'hB6);
        chk("R4 annunciator count", n_wr[3], 2);

        // R9: latched fields, counter untouched
        host_write(1'b0, 8'h95);
        for (int c = 0; c < 16; c++) begin
            host_write(1'b0, 8'h10 | 8'(c));
            chk("R9 contrast latch", contrast, c);
            chk("R9 counter kept on contrast", status_o, 8'h15);
        end
        for (int s = 0; s < 16; s++) begin
            host_write(1'b0, 8'h20 | 8'(s));
            chk("R9 scroll latch", scroll, s);
        end
        for (int p = 0; p < 8; p++) begin
            host_write(1'b0, 8'h08 | 8'(p));
            chk("R9 power latch", power, p);
        end
        chk("R9 contrast held", contrast, 15);
        chk("R9 scroll held", scroll, 15);
        chk("R9 counter kept", status_o, 8'h15);

        // R10: no-op instruction codes
        snap = total_wr();
        host_write(1'b0, 8'h00);
        for (int k = 4; k < 8; k++) host_write(1'b0, 8'(k));
        idle(2);
        chk("R10 counter unchanged", status_o, 8'h15);
        chk("R10 no memory write", total_wr(), snap);
        chk("R10 contrast unchanged", contrast, 15);
        chk("R10 scroll unchanged", scroll, 15);
        chk("R10 power unchanged", power, 7);

        // R6: return home from another target
        host_write(1'b0, 8'h65);
        snap = total_wr();
        host_write(1'b0, 8'h02);
        chk("R6 home counter", status_o, 0);
        idle(1);
        chk("R6 home writes nothing", total_wr(), snap);
        host_write(1'b1, 8'hAB);
        idle(1);
        chk("R6 home selects char memory", sh_dd[0], 8'hAB);
        chk("R6 glyph untouched", n_wr[1], 3);
        host_write(1'b0, 8'h03);
        chk("R6 home alt code", status_o, 0);

        // R7 / R8: clear with injected writes while busy
        base = dlog_n;
        host_write(1'b0, 8'h01);
        chk("R7 busy right after clear", status_o, 8'h80);
        busy_cnt = 0;
        while (status_o[7] && busy_cnt < 200) begin
            busy_cnt++;
            host_we    = (busy_cnt <= 3);
            host_rs    = (busy_cnt == 2);
            host_wdata = (busy_cnt == 1) ? 8'h8A : (busy_cnt == 2) ? 8'h55 : 8'h13;
            @(negedge clk);
        end
        host_we = 1'b0;
        chk("R7 busy window length", busy_cnt, 76);
        chk("R7 counter after clear", status_o, 0);
        chk("R8 contrast kept while busy", contrast, 15);
        idle(1);
        chk("R7 fill write count", dlog_n - base, 76);
        for (int a = 0; a < 76; a++) begin
            chk("R7 fill order", dlog[base + a], a);
            chk("R7 fill value", sh_dd[a], 8'h20);
        end
        host_write(1'b1, 8'h77);
        idle(1);
        chk("R7 write after clear lands at 0", sh_dd[0], 8'h77);
        chk("R8 busy data byte dropped", dlog_n - base, 77);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule